// File: doc/BRIEF.md
# Address-Filtering Asynchronous Serial Receiver

This block receives asynchronous serial words on one input line. A word starts with a low start bit. It then carries 8 or 9 data bits, least significant bit first, and ends with a high stop bit. A programmable divisor and a prescaler derive an oversampling tick from the core clock. Each bit lasts sixteen ticks. The line is checked in the middle of the start bit, and each data bit is taken as the majority of three samples around its centre. The line can be inverted ahead of all detection, so the block works with both inverting and non-inverting level shifters.

Received words go into a two-entry buffer. Each entry holds the byte, the ninth bit and a framing-error flag. A ready output stays high while the buffer holds anything, and a read strobe removes the oldest entry. If a word completes while both entries are occupied, the word is lost and a sticky overrun flag is raised. While that flag is set, no new word is stored. Dropping the receive enable clears the flag.

For multidrop buses, an address filter can be switched on in 9-bit mode. While it is on, only words whose ninth bit is 1 are stored. Controller firmware clears the filter once it has been addressed, so that the data words that follow are also stored.

Top module: `serial_rx_addr`

## Requirements
- R1: One oversampling tick occurs every M*(D+1) clock cycles and one bit lasts 16 ticks. M is 1 when `cfg_fast` and `cfg_wide` are both 1, 4 when exactly one of them is 1, and 16 when both are 0. D is `cfg_div` when `cfg_wide`=1 and only `cfg_div[7:0]` when `cfg_wide`=0.
- R2: A word is received least significant bit first. With `cfg_nine_bit`=0 it has 8 data bits and `rd_bit9` reads 0. With `cfg_nine_bit`=1 it has 9 data bits: the first eight appear on `rd_data` and the ninth on `rd_bit9`.
- R3: When `cfg_rx_inv`=1, the input is complemented before start detection and sampling. The idle line is then low and the start bit is high.
- R4: A falling edge starts a word only if the line is still low at the middle of the start bit. A shorter low pulse stores nothing.
- R5: Each data bit is the majority of three samples taken on consecutive ticks around the bit centre, so a disturbance that covers a single sample does not change the bit.
- R6: A stop bit sampled as 0 sets `rd_ferr`=1 for that word, and the word is still stored. A word with a correct stop bit has `rd_ferr`=0.
- R7: The buffer holds two words in arrival order. `rx_ready` is 1 while it is non-empty. `rd_strobe` removes the oldest word. `rd_strobe` on an empty buffer has no effect.
- R8: A word that completes while both entries are occupied and no read is under way is discarded and sets `ovr_err`. While `ovr_err` is 1, no word is stored, and the words already buffered stay readable.
- R9: While `cfg_rx_en`=0, `ovr_err` reads 0 and no word is received. Raising `cfg_rx_en` resumes reception.
- R10: With `cfg_nine_bit`=1 and `cfg_addr_det`=1, only words whose ninth bit is 1 are stored. With `cfg_nine_bit`=0, `cfg_addr_det` has no effect.
- R11: After reset, `rx_ready` and `ovr_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pin | input | 1 | Serial input line (asynchronous) |
| cfg_rx_en | input | 1 | Continuous receive enable; low clears overrun |
| cfg_rx_inv | input | 1 | Complement the input line |
| cfg_nine_bit | input | 1 | Select 9 data bits per word |
| cfg_addr_det | input | 1 | Store only words whose ninth bit is 1 (9-bit mode) |
| cfg_fast | input | 1 | Prescale selection bit A |
| cfg_wide | input | 1 | Prescale selection bit B and 16-bit divisor select |
| cfg_div | input | 16 | Baud divisor value |
| rd_strobe | input | 1 | Remove the oldest buffered word |
| rd_data | output | 8 | Oldest buffered byte |
| rd_bit9 | output | 1 | Ninth bit of the oldest word |
| rd_ferr | output | 1 | Framing error of the oldest word |
| rx_ready | output | 1 | Buffer non-empty |
| ovr_err | output | 1 | Sticky overrun flag |

## Verification
The address-filter property compares the configuration present when a word is written with that word's ninth bit. It therefore assumes that `cfg_nine_bit` and `cfg_addr_det` do not change while a word is on the line. The stimulus changes configuration only when the line is idle, and then waits several bit times before sending. The overrun properties assume that `rd_strobe` is a single-cycle pulse that reads the buffer's own head, and the bench drives it that way. The glitch tests on the start bit and on the data bits assume a bit time of 32 clocks, so that a 2-clock disturbance lands on exactly one sample tick.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int DATA_W    = 8;
    localparam int OSR       = 16;
    localparam int SHIFT_MAX = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic              ferr;
        logic              bit9;
        logic [DATA_W-1:0] data;
    } rx_word_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // prescale exponent: 0 -> x1, 2 -> x4, 4 -> x16
    function automatic logic [2:0] pre_shift(input logic fast, input logic wide);
        if (fast && wide)      return 3'd0;
        else if (fast || wide) return 3'd2;
        else                   return 3'd4;
    endfunction

endpackage

// File: rtl/srx_baud_gen.sv
module srx_baud_gen
    import srx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             fast,
    input  logic             wide,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + SHIFT_MAX + 1;

    logic [DIV_W-1:0] div_eff;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        div_eff = wide ? div : {{(DIV_W-8){1'b0}}, div[7:0]};
        limit   = ((CNT_W'(div_eff) + CNT_W'(1)) << pre_shift(fast, wide)) - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= limit) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CNT_W'(1);
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/srx_frame_rx.sv
module srx_frame_rx
    import srx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     tick,
    input  logic     line,
    input  logic     nine,
    output logic     done,
    output rx_word_t word
);
    localparam int PH_W   = $clog2(OSR);
    localparam int BITS_W = $clog2(DATA_W + 2);
    localparam logic [PH_W-1:0] MID_PH  = PH_W'(OSR / 2);
    localparam logic [PH_W-1:0] PRE_PH  = PH_W'(OSR / 2 - 1);
    localparam logic [PH_W-1:0] POST_PH = PH_W'(OSR / 2 + 1);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(OSR - 1);

    rx_state_e         st;
    logic [PH_W-1:0]   ph;
    logic [BITS_W-1:0] nbits;
    logic [BITS_W-1:0] frame_bits;
    logic [DATA_W:0]   sh;
    logic              s_a, s_b;
    logic              voted;

    always_comb begin
        frame_bits = nine ? BITS_W'(DATA_W + 1) : BITS_W'(DATA_W);
        voted      = maj3(s_a, s_b, line);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st    <= ST_IDLE;
            ph    <= '0;
            nbits <= '0;
            sh    <= '0;
            s_a   <= 1'b0;
            s_b   <= 1'b0;
            done  <= 1'b0;
            word  <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (st)
                    ST_IDLE: begin
                        if (!line) begin
                            st    <= ST_START;
                            ph    <= PH_W'(1);
                            nbits <= '0;
                        end
                    end
                    ST_START: begin
                        ph <= ph + 1'b1;
                        if (ph == MID_PH && line) st <= ST_IDLE;
                        else if (ph == LAST_PH)   st <= ST_DATA;
                    end
                    ST_DATA: begin
                        ph <= ph + 1'b1;
                        if (ph == PRE_PH) s_a <= line;
                        if (ph == MID_PH) s_b <= line;
                        if (ph == POST_PH) begin
                            sh    <= {voted, sh[DATA_W:1]};
                            nbits <= nbits + 1'b1;
                        end
                        if (ph == LAST_PH && nbits == frame_bits) st <= ST_STOP;
                    end
                    ST_STOP: begin
                        ph <= ph + 1'b1;
                        if (ph == PRE_PH) s_a <= line;
                        if (ph == MID_PH) s_b <= line;
                        if (ph == POST_PH) begin
                            done      <= 1'b1;
                            word.ferr <= !voted;
                            if (nine) begin
                                word.bit9 <= sh[DATA_W];
                                word.data <= sh[DATA_W-1:0];
                            end else begin
                                word.bit9 <= 1'b0;
                                word.data <= sh[DATA_W:1];
                            end
                            st <= ST_IDLE;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr,
    input  rx_word_t                   wdata,
    input  logic                       rd,
    output rx_word_t                   rdata,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_word_t         mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_wr, do_rd;

    always_comb begin
        empty = (cnt == '0);
        full  = (cnt == CNT_W'(DEPTH));
        do_rd = rd && !empty;
        do_wr = wr && (!full || do_rd);
        rdata = mem[rp];
    end

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= nxt(wp);
            if (do_rd) rp <= nxt(rp);
            if (do_wr && !do_rd)      cnt <= cnt + 1'b1;
            else if (do_rd && !do_wr) cnt <= cnt - 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)                          mem[i] <= '0;
                else if (do_wr && wp == PTR_W'(i)) mem[i] <= wdata;
            end
        end
    endgenerate

endmodule

// File: rtl/serial_rx_addr.sv
module serial_rx_addr
    import srx_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_pin,
    input  logic              cfg_rx_en,
    input  logic              cfg_rx_inv,
    input  logic              cfg_nine_bit,
    input  logic              cfg_addr_det,
    input  logic              cfg_fast,
    input  logic              cfg_wide,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit9,
    output logic              rd_ferr,
    output logic              rx_ready,
    output logic              ovr_err
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [1:0]       sync_q;
    logic             line;
    logic             tick;
    logic             done;
    rx_word_t         word;
    rx_word_t         head;
    logic             accept;
    logic             fifo_wr;
    logic             fifo_full;
    logic             fifo_empty;
    logic [CNT_W-1:0] fifo_cnt;
    logic             wr_bit9;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rx_pin};
    end

    assign line = sync_q[1] ^ cfg_rx_inv;

    srx_baud_gen #(.DIV_W(DIV_W)) baud_i (
        .clk  (clk),
        .rst  (rst),
        .run  (cfg_rx_en),
        .fast (cfg_fast),
        .wide (cfg_wide),
        .div  (cfg_div),
        .tick (tick)
    );

    srx_frame_rx frame_i (
        .clk  (clk),
        .rst  (rst),
        .en   (cfg_rx_en),
        .tick (tick),
        .line (line),
        .nine (cfg_nine_bit),
        .done (done),
        .word (word)
    );

    always_comb begin
        accept  = done && !(cfg_nine_bit && cfg_addr_det && !word.bit9);
        fifo_wr = accept && !ovr_err && (!fifo_full || rd_strobe);
        wr_bit9 = word.bit9;
    end

    always_ff @(posedge clk) begin
        if (rst || !cfg_rx_en)                             ovr_err <= 1'b0;
        else if (accept && !ovr_err && fifo_full && !rd_strobe) ovr_err <= 1'b1;
    end

    srx_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk   (clk),
        .rst   (rst),
        .wr    (fifo_wr),
        .wdata (word),
        .rd    (rd_strobe),
        .rdata (head),
        .cnt   (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    always_comb begin
        rd_data  = head.data;
        rd_bit9  = head.bit9;
        rd_ferr  = head.ferr;
        rx_ready = !fifo_empty;
    end

endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
    parameter int DEPTH = 2,
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_rx_en,
    input logic             cfg_nine_bit,
    input logic             cfg_addr_det,
    input logic             rd_strobe,
    input logic             rx_ready,
    input logic             ovr_err,
    input logic [7:0]       rd_data,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             fifo_wr,
    input logic             wr_bit9
);

    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (!rx_ready && !ovr_err));

    assert_fill_bound_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNT_W'(DEPTH));

    assert_head_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && !rd_strobe) |=> $stable(rd_data));

    assert_last_pop_R7: assert property (@(posedge clk) disable iff (rst)
        (fifo_cnt == CNT_W'(1) && rd_strobe && !fifo_wr) |=> !rx_ready);

    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_rx_en && ovr_err) |=> ovr_err);

    assert_ovr_needs_full_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_err) |-> ($past(fifo_cnt) == CNT_W'(DEPTH)));

    assert_no_store_in_ovr_R8: assert property (@(posedge clk) disable iff (rst)
        ovr_err |-> !fifo_wr);

    assert_ovr_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !cfg_rx_en |=> !ovr_err);

    assert_addr_filter_R10: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && cfg_nine_bit && cfg_addr_det) |-> wr_bit9);

endmodule

bind serial_rx_addr srx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_rx_en    (cfg_rx_en),
    .cfg_nine_bit (cfg_nine_bit),
    .cfg_addr_det (cfg_addr_det),
    .rd_strobe    (rd_strobe),
    .rx_ready     (rx_ready),
    .ovr_err      (ovr_err),
    .rd_data      (rd_data),
    .fifo_cnt     (fifo_cnt),
    .fifo_wr      (fifo_wr),
    .wr_bit9      (wr_bit9)
);

// File: tb/serial_rx_addr_tb.sv
`timescale 1ns/1ps
module serial_rx_addr_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_pin = 1'b1;
    logic        cfg_rx_en = 1'b1;
    logic        cfg_rx_inv = 1'b0;
    logic        cfg_nine_bit = 1'b0;
    logic        cfg_addr_det = 1'b0;
    logic        cfg_fast = 1'b1;
    logic        cfg_wide = 1'b1;
    logic [15:0] cfg_div = 16'd1;
    logic        rd_strobe = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_bit9, rd_ferr, rx_ready, ovr_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    serial_rx_addr dut_i (
        .clk(clk), .rst(rst), .rx_pin(rx_pin), .cfg_rx_en(cfg_rx_en),
        .cfg_rx_inv(cfg_rx_inv), .cfg_nine_bit(cfg_nine_bit),
        .cfg_addr_det(cfg_addr_det), .cfg_fast(cfg_fast), .cfg_wide(cfg_wide),
        .cfg_div(cfg_div), .rd_strobe(rd_strobe), .rd_data(rd_data),
        .rd_bit9(rd_bit9), .rd_ferr(rd_ferr), .rx_ready(rx_ready), .ovr_err(ovr_err)
    );

    // row: {store, stop, inv, addr, nine, data[8:0]}
    localparam logic [13:0] VEC [9] = '{
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h055},
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 9'h0A3},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 9'h1C4},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 9'h03A},
        {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 9'h0F0},
        {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 9'h181},
        {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 9'h07E},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h096},
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 9'h155}
    };

    function automatic int bit_clks();
        int m = (cfg_fast && cfg_wide) ? 1 : ((cfg_fast || cfg_wide) ? 4 : 16);
        int d = cfg_wide ? int'(cfg_div) : int'(cfg_div[7:0]);
        return 16 * m * (d + 1);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic level);
        rx_pin = level ^ cfg_rx_inv;
    endtask

    task automatic hold_bit(input logic level, input bit glitch);
        int bc = bit_clks();
        drive(level);
        if (glitch) begin
            wait_clks(bc / 2);
            drive(~level);
            wait_clks(2);
            drive(level);
            wait_clks(bc / 2 - 2);
        end else begin
            wait_clks(bc);
        end
    endtask

    task automatic send(input logic [8:0] d, input logic nine, input logic stopv, input int gbit);
        int nb = nine ? 9 : 8;
        hold_bit(1'b0, 1'b0);
        for (int i = 0; i < nb; i++) hold_bit(d[i], gbit == i);
        hold_bit(stopv, 1'b0);
        drive(1'b1);
        wait_clks(bit_clks() * 2);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        wait_clks(1);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_clks(5);
        rst = 1'b0;
        wait_clks(2);
        check("R11 ready after reset", rx_ready, 0);
        check("R11 overrun after reset", ovr_err, 0);

        // R2 R3 R6 R10: table of frames
        for (int r = 0; r < 9; r++) begin
            logic [13:0] v = VEC[r];
            string tag;
            @(negedge clk);
            cfg_nine_bit = v[9];
            cfg_addr_det = v[10];
            cfg_rx_inv   = v[11];
            drive(1'b1);
            wait_clks(bit_clks() * 3);
            send(v[8:0], v[9], v[12], -1);
            tag = v[11] ? "R3" : (v[10] ? "R10" : (!v[12] ? "R6" : "R2"));
            check($sformatf("%s row %0d ready", tag, r), rx_ready, v[13]);
            if (v[13]) begin
                check($sformatf("%s row %0d data", tag, r), rd_data, v[7:0]);
                check($sformatf("%s row %0d bit9", tag, r), rd_bit9, v[9] ? v[8] : 1'b0);
                check($sformatf("%s row %0d ferr", tag, r), rd_ferr, !v[12]);
                do_read();
                check($sformatf("R7 row %0d empty after read", r), rx_ready, 0);
            end
        end

        @(negedge clk);
        cfg_nine_bit = 0; cfg_addr_det = 0; cfg_rx_inv = 0;
        drive(1'b1);
        wait_clks(bit_clks() * 3);

        // R7: read on empty buffer has no effect
        do_read();
        check("R7 empty read ready", rx_ready, 0);
        send(9'h05A, 0, 1, -1);
        check("R7 one word ready", rx_ready, 1);
        check("R7 one word data", rd_data, 8'h5A);
        do_read();
        check("R7 single entry drained", rx_ready, 0);

        // R7 R8: two entries, then overrun
        send(9'h011, 0, 1, -1);
        send(9'h022, 0, 1, -1);
        check("R7 two entries oldest first", rd_data, 8'h11);
        check("R8 no overrun at two", ovr_err, 0);
        send(9'h033, 0, 1, -1);
        check("R8 overrun on third", ovr_err, 1);
        check("R8 head kept", rd_data, 8'h11);
        send(9'h044, 0, 1, -1);
        do_read();
        check("R8 second entry readable", rd_data, 8'h22);
        do_read();
        check("R8 later words lost", rx_ready, 0);
        check("R8 overrun sticky", ovr_err, 1);
        send(9'h045, 0, 1, -1);
        check("R8 frozen while overrun", rx_ready, 0);

        // R9: enable low clears overrun and stops reception
        @(negedge clk) cfg_rx_en = 1'b0;
        wait_clks(3);
        check("R9 overrun cleared", ovr_err, 0);
        send(9'h066, 0, 1, -1);
        check("R9 no reception when off", rx_ready, 0);
        @(negedge clk) cfg_rx_en = 1'b1;
        wait_clks(bit_clks());
        send(9'h077, 0, 1, -1);
        check("R9 resumed ready", rx_ready, 1);
        check("R9 resumed data", rd_data, 8'h77);
        do_read();

        // R4: short low pulse is not a start bit
        drive(1'b0);
        wait_clks(10);
        drive(1'b1);
        wait_clks(bit_clks() * 12);
        check("R4 short pulse rejected", rx_ready, 0);

        // R5: single-sample disturbances are voted out
        send(9'h000, 0, 1, 2);
        check("R5 low bit kept", rd_data, 8'h00);
        do_read();
        send(9'h0FF, 0, 1, 5);
        check("R5 high bit kept", rd_data, 8'hFF);
        do_read();

        // R1: other divisor and prescale settings
        @(negedge clk);
        cfg_fast = 0; cfg_wide = 0; cfg_div = 16'hFF00;
        wait_clks(bit_clks() * 2);
        send(9'h0C3, 0, 1, -1);
        check("R1 narrow x16 ready", rx_ready, 1);
        check("R1 narrow x16 data", rd_data, 8'hC3);
        do_read();
        @(negedge clk);
        cfg_fast = 0; cfg_wide = 1; cfg_div = 16'h0001;
        wait_clks(bit_clks() * 2);
        send(9'h081, 0, 1, -1);
        check("R1 wide x4 data", rd_data, 8'h81);
        check("R1 wide x4 ready", rx_ready, 1);
        do_read();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule